// File: doc/BRIEF.md
# System Timer with Output-Compare Channels

This block keeps a wide up-counter that starts at zero after reset and advances by one on every clock, never reloading and never stopping. Beside it sit a set of compare channels, each holding one compare word as wide as the counter's low half. A channel raises its sticky match flag when the counter's low half equals the compare word. Each flag drives its own interrupt line, so an interrupt controller can serve every channel separately.

Software reaches the block through a single-cycle valid/write/address/data port with combinational read data. One register shows all match flags and clears them when a 1 is written to a bit. The counter is read as two halves at separate addresses. A read of the low half captures the high half at the same moment, so the two reads together give one consistent count even when a carry falls between them. Compare words are written and read back at their own addresses. A typical use writes a compare word some ticks ahead of the current low half and then waits for that channel's interrupt.

Top module: `systmr_top`

## Requirements
- R1: The counter is 2*HALF_W bits wide. It advances by exactly one on every clock after reset, and a carry out of the low half increments the high half.
- R2: After reset the counter, every compare word and every match flag are zero, and every interrupt output is low.
- R3: No channel flags a match on the first cycle after reset, when the counter is still zero, even though the compare words are also zero.
- R4: If the low half equals channel i's compare word in a cycle, flag i is set from the next cycle on. Channel i's compare word is written and read at address 4+i.
- R5: Match flags are sticky. Writing to address 0 clears each flag whose bit (bit i for channel i) is written as 1. Bits written as 0 leave their flags unchanged.
- R6: Interrupt output i carries the level of match flag i.
- R7: The match check in a cycle uses the compare word held before that cycle. A write to the same channel's compare word in that cycle does not suppress the match, and the new word reads back afterwards.
- R8: If a match and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A read of address 1 returns the counter's low half and captures the high half. A read of address 2 returns the captured high half.
- R10: A read of address 0 returns the flags in bits NUM_CH-1:0, with zeros above. A match on one channel leaves the other channels' flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address: 0 flags, 1 low half, 2 captured high half, 4+i compare word i |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data, valid in the same cycle as a read access |
| match_irq | output | NUM_CH | Per-channel interrupt, the level of each match flag |

## Verification
Two pairs of events can fall in the same cycle. A match can coincide with a software write of that channel's compare word, and a match can coincide with a write-one clear of that channel's flag. The bench keeps its own tick count of the counter, waits until the low half equals the compare word, and issues the write or the clear in exactly that cycle. It then judges the case by the interrupt level and the read-back compare word in the following cycle. The bench also reads the low half at its all-ones value, so the high half rolls over before the high-half read, which shows whether the captured high half or the live one is returned.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
  // Word addresses on the register port; compare word i sits at CMP_BASE + i
  localparam int unsigned SYSTMR_ADDR_FLAGS  = 0;
  localparam int unsigned SYSTMR_ADDR_CNT_LO = 1;
  localparam int unsigned SYSTMR_ADDR_CNT_HI = 2;
  localparam int unsigned SYSTMR_ADDR_CMP    = 4;
endpackage

// File: rtl/systmr_counter.sv
module systmr_counter #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_read,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic [HALF_W-1:0] hi_snap,
  output logic              armed
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] snap_q, snap_d;
  logic              armed_q, armed_d;
  logic              snap_en;

  always_comb begin
    cnt_d   = cnt_q + CNT_W'(1);
    armed_d = 1'b1;
    snap_en = lo_read;
    snap_d  = cnt_q[CNT_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      if (snap_en) snap_q <= snap_d;
    end
  end

  assign cnt_lo  = cnt_q[HALF_W-1:0];
  assign cnt_hi  = cnt_q[CNT_W-1:HALF_W];
  assign hi_snap = snap_q;
  assign armed   = armed_q;
endmodule

// File: rtl/systmr_channel.sv
module systmr_channel #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic              armed,
  input  logic              cmp_we,
  input  logic [HALF_W-1:0] cmp_wdata,
  input  logic              flag_clr,
  output logic [HALF_W-1:0] cmp_val,
  output logic              flag
);
  logic [HALF_W-1:0] cmp_q, cmp_d;
  logic              flag_q, flag_d;
  logic              hit;

  always_comb begin
    hit    = armed && (cnt_lo == cmp_q);
    // a hit outranks a clear in the same cycle
    flag_d = hit | (flag_q & ~flag_clr);
    cmp_d  = cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (cmp_we) cmp_q <= cmp_d;
    end
  end

  assign cmp_val = cmp_q;
  assign flag    = flag_q;
endmodule

// File: rtl/systmr_top.sv
module systmr_top
  import systmr_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned ADDR_W = $clog2(SYSTMR_ADDR_CMP + NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] match_irq
);
  logic                          wr_acc, rd_acc;
  logic                          lo_read;
  logic [HALF_W-1:0]             cnt_lo, cnt_hi, hi_snap;
  logic                          armed;
  logic [NUM_CH-1:0]             cmp_we;
  logic [NUM_CH-1:0]             flag_clr;
  logic [NUM_CH-1:0]             flag_vec;
  logic [NUM_CH-1:0][HALF_W-1:0] cmp_vals;

  always_comb begin
    wr_acc  = bus_valid && bus_write;
    rd_acc  = bus_valid && !bus_write;
    lo_read = rd_acc && (bus_addr == ADDR_W'(SYSTMR_ADDR_CNT_LO));
    flag_clr = (wr_acc && (bus_addr == ADDR_W'(SYSTMR_ADDR_FLAGS)))
               ? bus_wdata[NUM_CH-1:0] : '0;
    for (int i = 0; i < NUM_CH; i++) begin
      cmp_we[i] = wr_acc && (bus_addr == ADDR_W'(SYSTMR_ADDR_CMP + i));
    end
  end

  systmr_counter #(.HALF_W(HALF_W)) i_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_read (lo_read),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .hi_snap (hi_snap),
    .armed   (armed)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    systmr_channel #(.HALF_W(HALF_W)) i_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_lo    (cnt_lo),
      .armed     (armed),
      .cmp_we    (cmp_we[g]),
      .cmp_wdata (bus_wdata),
      .flag_clr  (flag_clr[g]),
      .cmp_val   (cmp_vals[g]),
      .flag      (flag_vec[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      if (bus_addr == ADDR_W'(SYSTMR_ADDR_FLAGS))  bus_rdata = HALF_W'(flag_vec);
      if (bus_addr == ADDR_W'(SYSTMR_ADDR_CNT_LO)) bus_rdata = cnt_lo;
      if (bus_addr == ADDR_W'(SYSTMR_ADDR_CNT_HI)) bus_rdata = hi_snap;
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_addr == ADDR_W'(SYSTMR_ADDR_CMP + i)) bus_rdata = cmp_vals[i];
      end
    end
  end

  assign match_irq = flag_vec;
endmodule

// File: rtl/systmr_checker.sv
module systmr_checker #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_valid,
  input logic                          bus_write,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [HALF_W-1:0]             bus_wdata,
  input logic [HALF_W-1:0]             cnt_lo,
  input logic [HALF_W-1:0]             cnt_hi,
  input logic [HALF_W-1:0]             hi_snap,
  input logic                          armed,
  input logic [NUM_CH-1:0][HALF_W-1:0] cmp_vals,
  input logic [NUM_CH-1:0]             match_irq
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [NUM_CH-1:0] hits;
  logic [NUM_CH-1:0] clr_bits;
  logic [NUM_CH-1:0] keep;
  logic              lo_rd;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) hits[i] = armed && (cmp_vals[i] == cnt_lo);
    clr_bits = (bus_valid && bus_write && bus_addr == '0) ? bus_wdata[NUM_CH-1:0] : '0;
    keep     = match_irq & ~clr_bits;
    lo_rd    = bus_valid && !bus_write && (bus_addr == ADDR_W'(1));
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + CNT_W'(1)));

  assert_no_early_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (match_irq == '0));

  assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0) |=> ((match_irq & $past(hits)) == $past(hits)));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (keep != '0) |=> ((match_irq & $past(keep)) == $past(keep)));

  assert_irq_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((match_irq & ~$past(match_irq) & ~$past(hits)) == '0));

  assert_hi_snapshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (hi_snap == $past(cnt_hi)));
endmodule

bind systmr_top systmr_checker #(
  .HALF_W (HALF_W),
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_systmr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .hi_snap   (hi_snap),
  .armed     (armed),
  .cmp_vals  (cmp_vals),
  .match_irq (match_irq)
);

// File: tb/test_systmr_top.sv
module test_systmr_top;
  localparam int unsigned HW  = 8;
  localparam int unsigned NCH = 4;
  localparam int unsigned AW  = 3;
  localparam int unsigned LO_MOD = 1 << HW;

  logic          clk;
  logic          rst_n;
  logic          bus_valid;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [HW-1:0] bus_wdata;
  logic [HW-1:0] bus_rdata;
  logic [NCH-1:0] match_irq;

  int unsigned edges;
  int tests_run;
  int tests_failed;
  bit done;

  systmr_top #(.HALF_W(HW), .NUM_CH(NCH)) i_systmr_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .match_irq (match_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference tick count: number of clock edges since reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input int unsigned addr, input int unsigned data);
    bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = AW'(addr); bus_wdata = HW'(data);
    step();
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input int unsigned addr, output int unsigned data);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
    #1;
    data = bus_rdata;
    step();
    bus_valid = 1'b0;
  endtask

  task automatic wait_lo(input int unsigned val);
    while ((edges % LO_MOD) != val) step();
  endtask

  task automatic t_reset();
    int unsigned d;
    check("R2 irq in reset", match_irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_rd(1, d);
    check("R2 counter low after reset", d, 0);
    check("R3 no match before first advance", match_irq, 0);
    bus_rd(0, d);
    check("R2 flags after reset", d, 0);
    for (int i = 0; i < NCH; i++) begin
      bus_rd(4 + i, d);
      check("R2 compare after reset", d, 0);
    end
  endtask

  task automatic t_compare_setup();
    int unsigned d;
    for (int i = 0; i < NCH; i++) bus_wr(4 + i, 50 + 10 * i);
    for (int i = 0; i < NCH; i++) begin
      bus_rd(4 + i, d);
      check("R4 compare readback", d, 50 + 10 * i);
    end
  endtask

  task automatic t_counter();
    int unsigned d, e;
    e = edges;
    bus_rd(1, d);
    check("R1 counter low tracks ticks", d, e % LO_MOD);
    wait_lo(LO_MOD - 1);
    e = edges;
    bus_rd(1, d);
    check("R1 counter low at all ones", d, LO_MOD - 1);
    bus_rd(2, d);
    check("R9 captured high across carry", d, e / LO_MOD);
    repeat (7) step();
    e = edges;
    bus_rd(1, d);
    check("R1 low after carry", d, e % LO_MOD);
    bus_rd(2, d);
    check("R1 high half after carry", d, e / LO_MOD);
  endtask

  task automatic t_match(input int ch, input int unsigned cval);
    int unsigned d;
    logic [NCH-1:0] others;
    bus_wr(0, 1 << ch);
    wait_lo(cval);
    check("R4 flag clear before match", match_irq[ch], 0);
    others = match_irq & ~NCH'(1 << ch);
    step();
    check("R4 flag set after match", match_irq[ch], 1);
    check("R10 other channels unaffected", match_irq & ~NCH'(1 << ch), others);
    bus_rd(0, d);
    check("R10 status bit set", (d >> ch) & 1, 1);
    check("R10 status upper bits zero", d >> NCH, 0);
    bus_wr(0, 0);
    check("R5 write zero keeps flag", match_irq[ch], 1);
    bus_wr(0, 1 << ch);
    check("R6 irq drops after clear", match_irq[ch], 0);
    bus_rd(0, d);
    check("R5 status bit cleared", (d >> ch) & 1, 0);
  endtask

  task automatic t_same_cycle_write();
    int unsigned d;
    bus_wr(0, 1);
    wait_lo(50);
    bus_wr(4, 200);
    check("R7 match survives compare write", match_irq[0], 1);
    bus_rd(4, d);
    check("R7 new compare read back", d, 200);
    bus_wr(0, 1);
  endtask

  task automatic t_set_beats_clear();
    bus_wr(0, 2);
    wait_lo(60);
    bus_wr(0, 2);
    check("R8 set wins over clear", match_irq[1], 1);
    bus_wr(0, 2);
    check("R8 later clear works", match_irq[1], 0);
  endtask

  initial begin
    tests_run = 0; tests_failed = 0; done = 1'b0;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_compare_setup();
    t_counter();
    bus_wr(0, 'hF);
    for (int i = 0; i < NCH; i++) t_match(i, 50 + 10 * i);
    t_same_cycle_write();
    t_set_beats_clear();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule